// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block connects one frame-synchronized serial TDM line to a set of internal serial channel endpoints. A small route table is supplied as a flat vector. Each entry names a destination channel code, a set of strobe lines, a run length, a unit (bits or bytes) and an end-of-pass flag. A frame sync marks the start of a pass. After a one-bit delay, the sequencer walks the entries in ascending order. Every bit period of the pass is handed to the channel of the current entry, or to no channel at all.

The line clock is the block clock. Frame sync, the grant input and receive data are captured on the falling edge. The transmit pin, its output enable and the strobe lines change on the rising edge. On the transmit side, the bit offered by the selected endpoint is multiplexed onto the line, and the driver is released on every bit that belongs to no channel. On the receive side, each captured bit goes out with a one-hot valid flag for the owning channel. The grant input is captured together with frame sync and is held for the D-channel endpoint.

When the entry with its end flag set has finished, the line stays idle until the next frame sync. A frame sync that arrives while a pass is still running abandons that pass, restarts at entry 0 and produces a one-cycle error pulse.

Top module: `tdm_route_sequencer`

## Requirements
- R1: While rst_n is low, tx_oe, txd, strobe, ch_tx_req, ch_rx_vld, sync_err and dch_grant are all zero.
- R2: An entry with the byte flag set covers (count+1)*8 bit periods, and one with it clear covers count+1 bit periods. So count 0 gives 8 bits or 1 bit.
- R3: Entry i occupies route_tbl[13*i+12 : 13*i]. Within an entry, bit 12 is the end flag, bit 11 the byte flag, bits 10:7 the count, bits 6:3 the strobe set and bits 2:0 the channel code. Entries are taken in order from 0. A non-zero channel code c sets bit c of ch_tx_req and of ch_rx_vld. Code 0 routes to no channel.
- R4: tx_oe is high exactly during bit periods whose entry has a non-zero channel code. In those periods txd equals ch_tx_bit[code]. Otherwise txd is 0.
- R5: Frame sync is recognized by a rising level captured on a falling clock edge. The first data bit occupies the bit period after the one in which frame sync was high.
- R6: On each falling edge during a routed bit, rx_bit takes the value of rxd and ch_rx_vld marks the owning channel. Unrouted and idle bits give ch_rx_vld equal to 0.
- R7: During every bit period of an active entry, strobe equals that entry's strobe set, including on unrouted bits. Outside a pass it is 0.
- R8: A pass ends after the entry whose end flag is set, or after entry NENT-1 if no end flag is set. The block then idles with tx_oe, strobe and all valid and request bits at 0 until the next frame sync.
- R9: A frame sync recognized before the final bit of a pass produces a sync_err pulse of exactly one cycle and restarts the pass at entry 0, bit 0.
- R10: dch_grant takes the value of grant on the falling edge that recognizes frame sync, and it holds that value until the next frame sync.
- R11: A frame sync recognized during the final bit of a pass starts the next pass with no bit gap and with no sync_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, captured on the falling edge |
| grant | input | 1 | D-channel grant, captured with frame sync |
| rxd | input | 1 | Receive line data |
| route_tbl | input | NENT*13 | Packed route table |
| ch_tx_bit | input | 8 | Transmit bit offered by each channel code |
| txd | output | 1 | Transmit line data |
| tx_oe | output | 1 | Transmit driver enable (0 = tri-state) |
| strobe | output | 4 | Strobe lines of the active entry |
| ch_tx_req | output | 8 | One-hot transmit bit request per channel code |
| ch_rx_vld | output | 8 | One-hot receive bit valid per channel code |
| rx_bit | output | 1 | Captured receive bit |
| dch_grant | output | 1 | Grant indication for the D-channel endpoint |
| sync_err | output | 1 | One-cycle pulse on a premature frame sync |

## Verification
The bench targets the boundaries between entries and the boundary between passes. A span that is off by one shifts every later slot to the wrong channel. Mixing up byte and bit counting stretches or squeezes whole runs. A frame sync placed on the final bit checks that back-to-back frames run without a gap or a false error, while one placed mid-pass checks that the pass restarts at entry 0 instead of carrying on. The bench moves the grant input in the middle of a frame to expose a grant that is sampled continuously instead of at frame sync. Strobe sets placed on unrouted entries expose strobes that are wrongly tied to output enable.

// File: rtl/tdm_route_pkg.sv
`timescale 1ns/1ps
package tdm_route_pkg;
  localparam int CH_W   = 3;
  localparam int STB_W  = 4;
  localparam int CNT_W  = 4;
  localparam int ENT_W  = CH_W + STB_W + CNT_W + 2;
  localparam int NCODE  = 1 << CH_W;
  localparam int SPAN_W = CNT_W + 4;

  typedef struct packed {
    logic              last;
    logic              bytes;
    logic [CNT_W-1:0]  cnt;
    logic [STB_W-1:0]  strb;
    logic [CH_W-1:0]   ch;
  } route_ent_t;

  // Number of bit periods one entry covers.
  function automatic logic [SPAN_W-1:0] ent_span(route_ent_t e);
    logic [SPAN_W-1:0] n;
    n = SPAN_W'(e.cnt) + SPAN_W'(1);
    return e.bytes ? (n << 3) : n;
  endfunction

  function automatic logic [NCODE-1:0] code_onehot(logic [CH_W-1:0] c);
    return (c == '0) ? '0 : (NCODE'(1) << c);
  endfunction
endpackage

// File: rtl/tdm_edge_sampler.sv
`timescale 1ns/1ps
module tdm_edge_sampler
  import tdm_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             grant,
  input  logic             rxd,
  input  logic             cur_active,
  input  logic [CH_W-1:0]  cur_ch,
  output logic             fs_evt,
  output logic             dch_grant,
  output logic             rx_bit,
  output logic [NCODE-1:0] rx_vld
);
  logic fs_last;
  logic fs_rise;

  assign fs_rise = fsync & ~fs_last;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_last   <= 1'b0;
      fs_evt    <= 1'b0;
      dch_grant <= 1'b0;
      rx_bit    <= 1'b0;
      rx_vld    <= '0;
    end else begin
      fs_last <= fsync;
      fs_evt  <= fs_rise;
      if (fs_rise) dch_grant <= grant;
      rx_bit  <= rxd;
      rx_vld  <= cur_active ? code_onehot(cur_ch) : '0;
    end
  end
endmodule

// File: rtl/tdm_route_seq.sv
`timescale 1ns/1ps
module tdm_route_seq
  import tdm_route_pkg::*;
#(
  parameter  int NENT  = 8,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NENT*ENT_W-1:0] route_tbl,
  input  logic                  fs_evt,
  output logic                  active,
  output logic [IDX_W-1:0]      idx,
  output logic [SPAN_W-1:0]     bcnt,
  output route_ent_t            cur,
  output logic                  sync_err
);
  route_ent_t        ents [NENT];
  logic [SPAN_W-1:0] span_now;
  logic              at_end;
  logic              last_ent;
  logic              pass_done;

  for (genvar gi = 0; gi < NENT; gi++) begin : g_unpack
    assign ents[gi] = route_ent_t'(route_tbl[gi*ENT_W +: ENT_W]);
  end

  assign cur       = ents[idx];
  assign span_now  = ent_span(cur);
  assign at_end    = (bcnt == span_now - SPAN_W'(1));
  assign last_ent  = cur.last || (idx == IDX_W'(NENT-1));
  assign pass_done = active && at_end && last_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      bcnt     <= '0;
      sync_err <= 1'b0;
    end else if (fs_evt) begin
      sync_err <= active && !pass_done;
      active   <= 1'b1;
      idx      <= '0;
      bcnt     <= '0;
    end else begin
      sync_err <= 1'b0;
      if (active) begin
        if (at_end) begin
          bcnt <= '0;
          if (last_ent) begin
            active <= 1'b0;
            idx    <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end else begin
          bcnt <= bcnt + SPAN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_mux.sv
`timescale 1ns/1ps
module tdm_slot_mux
  import tdm_route_pkg::*;
(
  input  logic             active,
  input  route_ent_t       cur,
  input  logic [NCODE-1:0] ch_tx_bit,
  output logic             txd,
  output logic             tx_oe,
  output logic [STB_W-1:0] strobe,
  output logic [NCODE-1:0] tx_req
);
  logic routed;

  always_comb begin
    routed = active && (cur.ch != '0);
    tx_oe  = routed;
    txd    = routed & ch_tx_bit[cur.ch];
    tx_req = routed ? code_onehot(cur.ch) : '0;
    strobe = active ? cur.strb : '0;
  end
endmodule

// File: rtl/tdm_route_sequencer.sv
`timescale 1ns/1ps
module tdm_route_sequencer
  import tdm_route_pkg::*;
#(
  parameter  int NENT  = 8,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  grant,
  input  logic                  rxd,
  input  logic [NENT*ENT_W-1:0] route_tbl,
  input  logic [NCODE-1:0]      ch_tx_bit,
  output logic                  txd,
  output logic                  tx_oe,
  output logic [STB_W-1:0]      strobe,
  output logic [NCODE-1:0]      ch_tx_req,
  output logic [NCODE-1:0]      ch_rx_vld,
  output logic                  rx_bit,
  output logic                  dch_grant,
  output logic                  sync_err
);
  logic              fs_evt;
  logic              seq_active;
  logic [IDX_W-1:0]  seq_idx;
  logic [SPAN_W-1:0] seq_bcnt;
  route_ent_t        seq_ent;

  tdm_edge_sampler u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .grant      (grant),
    .rxd        (rxd),
    .cur_active (seq_active),
    .cur_ch     (seq_ent.ch),
    .fs_evt     (fs_evt),
    .dch_grant  (dch_grant),
    .rx_bit     (rx_bit),
    .rx_vld     (ch_rx_vld)
  );

  tdm_route_seq #(.NENT(NENT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .route_tbl (route_tbl),
    .fs_evt    (fs_evt),
    .active    (seq_active),
    .idx       (seq_idx),
    .bcnt      (seq_bcnt),
    .cur       (seq_ent),
    .sync_err  (sync_err)
  );

  tdm_slot_mux u_mux (
    .active    (seq_active),
    .cur       (seq_ent),
    .ch_tx_bit (ch_tx_bit),
    .txd       (txd),
    .tx_oe     (tx_oe),
    .strobe    (strobe),
    .tx_req    (ch_tx_req)
  );
endmodule

// File: rtl/tdm_route_sva.sv
`timescale 1ns/1ps
module tdm_route_sva
  import tdm_route_pkg::*;
#(
  parameter  int NENT  = 8,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              fs_evt,
  input logic              active,
  input logic [IDX_W-1:0]  idx,
  input logic [SPAN_W-1:0] bcnt,
  input route_ent_t        ent,
  input logic              sync_err,
  input logic              tx_oe,
  input logic [NCODE-1:0]  tx_req,
  input logic [STB_W-1:0]  strobe,
  input logic [NCODE-1:0]  rx_vld,
  input logic              dch_grant
);
  p_oe_routed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> (active && $onehot(tx_req) && !tx_req[0]));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!tx_oe && strobe == '0 && tx_req == '0));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);

  p_err_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (active && idx == '0 && bcnt == '0));

  p_span_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bcnt < ent_span(ent)));

  p_advance_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(fs_evt) && idx != $past(idx))
      |-> ($past(bcnt) == ent_span($past(ent)) - SPAN_W'(1)));

  p_rx_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_vld) && !rx_vld[0]);

  p_grant_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dch_grant) |-> fs_evt);
endmodule

bind tdm_route_sequencer tdm_route_sva #(.NENT(NENT)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .fs_evt    (fs_evt),
  .active    (seq_active),
  .idx       (seq_idx),
  .bcnt      (seq_bcnt),
  .ent       (seq_ent),
  .sync_err  (sync_err),
  .tx_oe     (tx_oe),
  .tx_req    (ch_tx_req),
  .strobe    (strobe),
  .rx_vld    (ch_rx_vld),
  .dch_grant (dch_grant)
);

// File: tb/test_tdm_route_sequencer.sv
`timescale 1ns/1ps
module test_tdm_route_sequencer;
  import tdm_route_pkg::*;
  localparam int NENT = 8;
  localparam int TBLW = NENT * 13;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            fsync = 1'b0, grant = 1'b0, rxd = 1'b0;
  logic [TBLW-1:0] tbl = '0;
  logic [7:0]      ctx = '0;
  logic            txd, tx_oe, rx_bit, dch_grant, sync_err;
  logic [3:0]      strobe;
  logic [7:0]      ch_tx_req, ch_rx_vld;

  tdm_route_sequencer #(.NENT(NENT)) i_tdm_route_sequencer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .grant(grant), .rxd(rxd),
    .route_tbl(tbl), .ch_tx_bit(ctx), .txd(txd), .tx_oe(tx_oe),
    .strobe(strobe), .ch_tx_req(ch_tx_req), .ch_rx_vld(ch_rx_vld),
    .rx_bit(rx_bit), .dch_grant(dch_grant), .sync_err(sync_err)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // reference model state
  bit e_act = 0, prev_fs = 0, prev_g = 0, e_gnt = 0, e_err = 0;
  int e_j = 0;

  function automatic logic [12:0] mk(int ch, int st, int cnt, bit byt, bit lst);
    return {lst, byt, cnt[3:0], st[3:0], ch[2:0]};
  endfunction

  function automatic int f_cnt(int i);  return int'(tbl[i*13+7 +: 4]); endfunction
  function automatic int f_ch(int i);   return int'(tbl[i*13 +: 3]);   endfunction
  function automatic int f_stb(int i);  return int'(tbl[i*13+3 +: 4]); endfunction
  function automatic bit f_byt(int i);  return tbl[i*13+11];           endfunction
  function automatic bit f_lst(int i);  return tbl[i*13+12];           endfunction

  function automatic int espan(int i);
    int bits = f_cnt(i) + 1;
    if (f_byt(i)) bits = bits * 8;
    return bits;
  endfunction

  function automatic int pass_len();
    int acc = 0;
    for (int i = 0; i < NENT; i++) begin
      acc += espan(i);
      if (f_lst(i)) break;
    end
    return acc;
  endfunction

  function automatic int find_ent(int j);
    int acc = 0;
    for (int i = 0; i < NENT; i++) begin
      if (j < acc + espan(i)) return i;
      acc += espan(i);
      if (f_lst(i)) return -1;
    end
    return -1;
  endfunction

  task automatic chk(string req, string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual=%0d expected=%0d at %0t", req, tag, what, act, exp, $time);
    end
  endtask

  // Runs nper bit periods, with frame sync high in periods fs_a and fs_b.
  task automatic run(int nper, int fs_a, int fs_b, bit ginv, string tag);
    int tot = pass_len();
    for (int p = 0; p < nper; p++) begin
      int k, ech, est;
      bit routed, rin;
      @(posedge clk); #2;
      e_err = 0;
      if (prev_fs) begin
        e_err = e_act && (e_j != tot - 1);
        e_act = 1; e_j = 0; e_gnt = prev_g;
      end else if (e_act) begin
        e_j++;
        if (e_j >= tot) e_act = 0;
      end
      fsync = (p == fs_a) || (p == fs_b);
      grant = p[1] ^ ginv;
      rin   = p[0] ^ p[2] ^ p[3];
      rxd   = rin;
      ctx   = 8'(p * 29 + 11) ^ 8'(p >> 2);
      prev_fs = fsync; prev_g = grant;
      k   = e_act ? find_ent(e_j) : -1;
      ech = (k >= 0) ? f_ch(k) : 0;
      est = (k >= 0) ? f_stb(k) : 0;
      routed = (ech != 0);
      #3;
      chk("R4 R5 R8", tag, "tx_oe", int'(tx_oe), int'(routed));
      chk("R4", tag, "txd", int'(txd), routed ? int'(ctx[ech]) : 0);
      chk("R3", tag, "ch_tx_req", int'(ch_tx_req), routed ? (1 << ech) : 0);
      chk("R7 R8", tag, "strobe", int'(strobe), est);
      chk("R9 R11", tag, "sync_err", int'(sync_err), int'(e_err));
      chk("R10", tag, "dch_grant", int'(dch_grant), int'(e_gnt));
      @(negedge clk); #5;
      chk("R6 R3", tag, "ch_rx_vld", int'(ch_rx_vld), routed ? (1 << ech) : 0);
      if (routed) chk("R6", tag, "rx_bit", int'(rx_bit), int'(rin));
    end
  endtask

  task automatic load_example();
    tbl = '0;
    tbl[0*13 +: 13] = mk(2, 0, 0, 1, 0);
    tbl[1*13 +: 13] = mk(3, 0, 0, 0, 0);
    tbl[2*13 +: 13] = mk(0, 0, 0, 0, 0);
    tbl[3*13 +: 13] = mk(6, 0, 0, 1, 0);
    tbl[4*13 +: 13] = mk(3, 1, 0, 0, 1);
  endtask

  task automatic t_reset();   // R1
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "reset", "tx_oe", int'(tx_oe), 0);
    chk("R1", "reset", "txd", int'(txd), 0);
    chk("R1", "reset", "strobe", int'(strobe), 0);
    chk("R1", "reset", "ch_tx_req", int'(ch_tx_req), 0);
    chk("R1", "reset", "ch_rx_vld", int'(ch_rx_vld), 0);
    chk("R1", "reset", "sync_err", int'(sync_err), 0);
    chk("R1", "reset", "dch_grant", int'(dch_grant), 0);
    @(posedge clk); #2 rst_n = 1'b1;
  endtask

  task automatic t_example();   // R2 R3 R5 R6: 8+1+1+8+1 layout, grant captured high
    load_example();
    run(23, 0, -1, 1'b1, "example R2");
  endtask

  task automatic t_byte_runs();   // R2 R8: end flag mid-table, strobe on unrouted slot
    tbl = '0;
    tbl[0*13 +: 13] = mk(6, 2, 1, 1, 0);
    tbl[1*13 +: 13] = mk(2, 4, 3, 0, 0);
    tbl[2*13 +: 13] = mk(0, 8, 2, 0, 1);
    tbl[3*13 +: 13] = mk(3, 15, 5, 1, 0);
    run(27, 0, -1, 1'b0, "byte_runs R2 R8");
  endtask

  task automatic t_no_end_flag();   // R8: pass ends after entry NENT-1
    int codes [8] = '{2, 0, 3, 6, 2, 6, 0, 3};
    tbl = '0;
    for (int i = 0; i < NENT; i++)
      tbl[i*13 +: 13] = mk(codes[i], i + 1, i % 3, 0, 0);
    run(19, 0, -1, 1'b1, "table_end R8");
  endtask

  task automatic t_early_sync();   // R9: sync in mid-pass restarts at entry 0
    load_example();
    run(29, 0, 6, 1'b0, "early_sync R9");
  endtask

  task automatic t_back_to_back();   // R11: sync on final bit, no gap
    load_example();
    run(43, 0, 19, 1'b1, "back_to_back R11");
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    t_reset();
    t_example();
    t_byte_runs();
    t_no_end_flag();
    t_early_sync();
    t_back_to_back();
    done = 1;
    finish_up();
  end
endmodule